// File: doc/BRIEF.md
# SDRAM burst column address generator

This block produces the column address for every beat of a DRAM read or write burst. A controller presents a start column together with the burst settings taken from its mode register (a length code and an ordering select) and pulses a start strobe. From the next clock on, the block emits one column address per cycle, with a valid flag and a flag on the final beat. Data movement, byte masks and CAS latency are handled elsewhere.

Fixed-length bursts of 2, 4 or 8 beats wrap inside the aligned block of that size. Only the low address bits move, in sequential or interleaved order. Full-page mode walks the whole 512-column row from the start column and wraps from the top column to zero. It runs until it is stopped. A terminate input ends any burst at once. A fresh start strobe on any cycle abandons the running burst and begins a new one.

Top module: `colgen_burst_addr`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `valid_o` and `last_o` are 0.
- R2: When `start_i` is 1 at a clock edge, `valid_o` is 1 after that edge and `col_o` equals the `start_col_i` value that was sampled at that edge (beat 0).
- R3: The length code `blen_i` sets the number of beats, after which `valid_o` returns to 0. The codes are 0 for 1 beat, 1 for 2 beats, 2 for 4 beats, 3 for 8 beats and 7 for full page. Codes 4, 5 and 6 give a single beat.
- R4: With `ilv_i`=0 and a fixed length L, beat k carries the start column's upper bits unchanged (the bits above log2(L)). The low log2(L) bits are (start + k) mod L.
- R5: With `ilv_i`=1 and a fixed length L, beat k has the low log2(L) bits equal to the start column's low bits XOR k. The upper bits are unchanged.
- R6: In full page (code 7), beat k is (start + k) mod 512, whatever the value of `ilv_i`. The burst continues until it is terminated or restarted.
- R7: `last_o` is 1 only on the final beat of a fixed-length burst. It is never 1 in full page, and it is never 1 without `valid_o`.
- R8: When `stop_i` is 1 at a clock edge and `start_i` is 0, `valid_o` is 0 after that edge. If both are 1 at the same edge, the start takes effect.
- R9: A start strobe during a running burst restarts at once. The next beat is the new start column, using the newly sampled length and ordering.
- R10: `blen_i` and `ilv_i` are sampled only at a start. Changing them during a burst does not change the address sequence or the burst length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe; loads a new burst |
| start_col_i | input | 9 | Start column of the burst |
| blen_i | input | 3 | Burst length code (see R3) |
| ilv_i | input | 1 | 0 sequential, 1 interleaved ordering |
| stop_i | input | 1 | Burst terminate |
| col_o | output | 9 | Column address of the current beat |
| valid_o | output | 1 | A beat is present on `col_o` |
| last_o | output | 1 | Final beat of a fixed-length burst |

## Verification
The bench builds the block with its default parameters: a 9-bit column, a 3-bit length code and a largest fixed burst of 8 beats. With these values the 512-column wrap of full-page mode falls within a run of a few hundred cycles. The aligned-block wrap and the XOR ordering can then be checked at every fixed length on start columns whose low bits are not zero. This also gives room for reserved length codes, termination, restart in the middle of a burst, and input changes after the burst has been sampled.

// File: rtl/colgen_pkg.sv
package colgen_pkg;

  // width of the log2(length) field of a latched burst mode
  localparam int LG_W = 3;

  typedef struct packed {
    logic            full;  // full-page walk
    logic            ilv;   // interleaved ordering
    logic [LG_W-1:0] lg;    // log2 of fixed burst length
  } burst_mode_t;

endpackage

// File: rtl/colgen_mode_dec.sv
module colgen_mode_dec
  import colgen_pkg::*;
#(
  parameter int BL_W   = 3,
  parameter int MAX_LG = 3
) (
  input  logic [BL_W-1:0] blen_code,
  input  logic            ilv_sel,
  output burst_mode_t     mode
);

  localparam logic [BL_W-1:0] FULL_CODE = '1;

  always_comb begin
    mode.full = (blen_code == FULL_CODE);
    // full page always walks sequentially
    mode.ilv  = ilv_sel & ~mode.full;
    mode.lg   = '0;
    // reserved codes fall back to a single beat
    if (!mode.full && (int'(blen_code) <= MAX_LG))
      mode.lg = LG_W'(blen_code);
  end

endmodule

// File: rtl/colgen_addr_calc.sv
module colgen_addr_calc
  import colgen_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] beat,
  input  burst_mode_t      mode,
  output logic [COL_W-1:0] col,
  output logic             final_beat
);

  // ones in the low lg bits: selects the bits that move inside the block
  function automatic logic [COL_W-1:0] blk_mask(input logic [LG_W-1:0] lg);
    logic [COL_W-1:0] m;
    m = '0;
    for (int i = 0; i < COL_W; i++)
      if (i < int'(lg)) m[i] = 1'b1;
    return m;
  endfunction

  // sequential order: low bits count up from the start and wrap in the block
  function automatic logic [COL_W-1:0] seq_col(input logic [COL_W-1:0] b,
                                                input logic [COL_W-1:0] k,
                                                input logic [COL_W-1:0] m);
    return (b & ~m) | ((b + k) & m);
  endfunction

  // interleaved order: low bits are the start bits XOR the beat number
  function automatic logic [COL_W-1:0] ilv_col(input logic [COL_W-1:0] b,
                                                input logic [COL_W-1:0] k,
                                                input logic [COL_W-1:0] m);
    return (b & ~m) | ((b ^ k) & m);
  endfunction

  logic [COL_W-1:0] mask;

  always_comb begin
    mask = blk_mask(mode.lg);
    if (mode.full)
      col = base + beat;             // modulo 2**COL_W across the row
    else if (mode.ilv)
      col = ilv_col(base, beat, mask);
    else
      col = seq_col(base, beat, mask);
    final_beat = !mode.full && (beat == mask);
  end

endmodule

// File: rtl/colgen_beat_ctr.sv
module colgen_beat_ctr
  import colgen_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  input  logic [COL_W-1:0] start_col,
  input  burst_mode_t      mode_in,
  input  logic             final_beat,
  output logic             active,
  output logic [COL_W-1:0] beat,
  output logic [COL_W-1:0] base,
  output burst_mode_t      mode_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      beat   <= '0;
      base   <= '0;
      mode_q <= '0;
    end else if (start) begin
      // a start wins over terminate and over a running burst
      active <= 1'b1;
      beat   <= '0;
      base   <= start_col;
      mode_q <= mode_in;
    end else if (stop) begin
      active <= 1'b0;
      beat   <= '0;
    end else if (active) begin
      if (final_beat) begin
        active <= 1'b0;
        beat   <= '0;
      end else begin
        beat <= beat + COL_W'(1);
      end
    end
  end

endmodule

// File: rtl/colgen_burst_addr.sv
module colgen_burst_addr
  import colgen_pkg::*;
#(
  parameter int COL_W  = 9,
  parameter int BL_W   = 3,
  parameter int MAX_LG = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [BL_W-1:0]  blen_i,
  input  logic             ilv_i,
  input  logic             stop_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o
);

  burst_mode_t      mode_new;
  burst_mode_t      mode_q;
  logic             active;
  logic [COL_W-1:0] beat;
  logic [COL_W-1:0] base;
  logic [COL_W-1:0] col;
  logic             final_beat;

  // named events for the checker
  logic             mode_full;
  logic             burst_end_evt;

  colgen_mode_dec #(.BL_W(BL_W), .MAX_LG(MAX_LG)) u_dec (
    .blen_code (blen_i),
    .ilv_sel   (ilv_i),
    .mode      (mode_new)
  );

  colgen_beat_ctr #(.COL_W(COL_W)) u_ctr (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start_i),
    .stop       (stop_i),
    .start_col  (start_col_i),
    .mode_in    (mode_new),
    .final_beat (final_beat),
    .active     (active),
    .beat       (beat),
    .base       (base),
    .mode_q     (mode_q)
  );

  colgen_addr_calc #(.COL_W(COL_W)) u_calc (
    .base       (base),
    .beat       (beat),
    .mode       (mode_q),
    .col        (col),
    .final_beat (final_beat)
  );

  assign mode_full     = mode_q.full;
  assign burst_end_evt = active & final_beat;

  assign col_o   = col;
  assign valid_o = active;
  assign last_o  = burst_end_evt;

endmodule

// File: rtl/colgen_burst_addr_chk.sv
module colgen_burst_addr_chk #(
  parameter int COL_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [COL_W-1:0] start_col_i,
  input logic             stop_i,
  input logic [COL_W-1:0] col_o,
  input logic             valid_o,
  input logic             last_o,
  input logic             mode_full
);

  // R2
  start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (valid_o && col_o == $past(start_col_i)));

  // R8
  stop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !start_i) |=> !valid_o);

  // R7
  last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> valid_o);

  // R7
  full_no_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && mode_full) |-> !last_o);

  // R3
  last_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last_o && !start_i) |=> !valid_o);

  // R6
  full_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && mode_full && !start_i && !stop_i)
      |=> (valid_o && col_o == $past(col_o) + COL_W'(1)));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_o && !start_i) |=> !valid_o);

endmodule

bind colgen_burst_addr colgen_burst_addr_chk #(.COL_W(COL_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .start_col_i (start_col_i),
  .stop_i      (stop_i),
  .col_o       (col_o),
  .valid_o     (valid_o),
  .last_o      (last_o),
  .mode_full   (mode_full)
);

// File: tb/tb_colgen_burst_addr.sv
`timescale 1ns/1ps
module tb_colgen_burst_addr;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start;
  logic [8:0] scol;
  logic [2:0] blen;
  logic       ilv;
  logic       stop;
  logic [8:0] col;
  logic       valid;
  logic       last;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  colgen_burst_addr dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .start_col_i(scol),
    .blen_i(blen), .ilv_i(ilv), .stop_i(stop),
    .col_o(col), .valid_o(valid), .last_o(last)
  );

  // stimulus / expected table for fixed-length bursts (R4, R5, R3, R7)
  localparam int NV = 7;
  localparam logic [8:0] V_COL [NV] = '{9'h005, 9'h005, 9'h006, 9'h005,
                                        9'h10B, 9'h10B, 9'h1FE};
  localparam logic [2:0] V_BL  [NV] = '{3'd0, 3'd1, 3'd2, 3'd2, 3'd3, 3'd3, 3'd1};
  localparam logic       V_ILV [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1};
  localparam int         V_LEN [NV] = '{1, 2, 4, 4, 8, 8, 2};
  localparam logic [8:0] V_EXP [NV][8] = '{
    '{9'h005, 9'h000, 9'h000, 9'h000, 9'h000, 9'h000, 9'h000, 9'h000},
    '{9'h005, 9'h004, 9'h000, 9'h000, 9'h000, 9'h000, 9'h000, 9'h000},
    '{9'h006, 9'h007, 9'h004, 9'h005, 9'h000, 9'h000, 9'h000, 9'h000},
    '{9'h005, 9'h004, 9'h007, 9'h006, 9'h000, 9'h000, 9'h000, 9'h000},
    '{9'h10B, 9'h10C, 9'h10D, 9'h10E, 9'h10F, 9'h108, 9'h109, 9'h10A},
    '{9'h10B, 9'h10A, 9'h109, 9'h108, 9'h10F, 9'h10E, 9'h10D, 9'h10C},
    '{9'h1FE, 9'h1FF, 9'h000, 9'h000, 9'h000, 9'h000, 9'h000, 9'h000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // returns at the negedge where beat 0 is visible
  task automatic launch(input logic [8:0] c, input logic [2:0] b, input logic il);
    @(negedge clk);
    start = 1'b1; stop = 1'b0; scol = c; blen = b; ilv = il;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; stop = 1'b0; scol = '0; blen = '0; ilv = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk("R1 valid in reset", 32'(valid), 0);
      chk("R1 last in reset", 32'(last), 0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid after reset", 32'(valid), 0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      launch(V_COL[v], V_BL[v], V_ILV[v]);
      for (int k = 0; k < V_LEN[v]; k++) begin
        chk(V_ILV[v] ? "R5 interleaved col" : "R4 sequential col", 32'(col), 32'(V_EXP[v][k]));
        chk(k == 0 ? "R2 beat0 valid" : "R3 valid in burst", 32'(valid), 1);
        chk("R7 last flag", 32'(last), (k == V_LEN[v] - 1) ? 1 : 0);
        @(negedge clk);
      end
      chk("R3 burst length end", 32'(valid), 0);
    end

    // full page, interleave select ignored, wraps past 511
    launch(9'h1FD, 3'd7, 1'b1);
    for (int k = 0; k < 600; k++) begin
      chk("R6 full page col", 32'(col), 32'((9'h1FD + k) % 512));
      chk("R6 full page valid", 32'(valid), 1);
      chk("R7 no last in full page", 32'(last), 0);
      @(negedge clk);
    end
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    chk("R8 stop ends full page", 32'(valid), 0);

    // terminate a fixed burst mid-way
    launch(9'h040, 3'd3, 1'b0);
    @(negedge clk);
    chk("R4 beat1 before stop", 32'(col), 32'h041);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    chk("R8 stop mid burst", 32'(valid), 0);
    @(negedge clk);
    chk("R8 stays idle", 32'(valid), 0);

    // restart during a running burst
    launch(9'h020, 3'd3, 1'b0);
    @(negedge clk);
    @(negedge clk);
    chk("R4 beat2 before restart", 32'(col), 32'h022);
    start = 1'b1; scol = 9'h033; blen = 3'd1; ilv = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R9 restart col", 32'(col), 32'h033);
    chk("R9 restart not last", 32'(last), 0);
    @(negedge clk);
    chk("R9 restart beat1 col", 32'(col), 32'h032);
    chk("R9 restart last", 32'(last), 1);
    @(negedge clk);
    chk("R9 restart length", 32'(valid), 0);

    // mode inputs changed after start
    launch(9'h00C, 3'd2, 1'b0);
    blen = 3'd7; ilv = 1'b1;
    for (int k = 0; k < 4; k++) begin
      chk("R10 col unaffected", 32'(col), 32'(9'h00C + k));
      chk("R10 last unaffected", 32'(last), (k == 3) ? 1 : 0);
      @(negedge clk);
    end
    chk("R10 length unaffected", 32'(valid), 0);

    // reserved length code gives one beat
    launch(9'h077, 3'd5, 1'b0);
    chk("R3 reserved code col", 32'(col), 32'h077);
    chk("R3 reserved code last", 32'(last), 1);
    @(negedge clk);
    chk("R3 reserved code single beat", 32'(valid), 0);

    // start and stop at the same edge
    @(negedge clk);
    start = 1'b1; stop = 1'b1; scol = 9'h1A0; blen = 3'd0; ilv = 1'b0;
    @(negedge clk);
    start = 1'b0; stop = 1'b0;
    chk("R8 start wins valid", 32'(valid), 1);
    chk("R8 start wins col", 32'(col), 32'h1A0);
    @(negedge clk);
    chk("R8 start wins then ends", 32'(valid), 0);

    finish_run();
  end

endmodule